// File: doc/BRIEF.md
# Modem Status Tracker with Loopback Mapping

This block holds the modem control byte of a serial-port register model and produces the matching modem status byte. Software writes the control byte through a small write port; the block works out the four line states (clear-to-send, data-set-ready, ring, carrier) that follow from it. Any change in a line state sets a sticky change flag in the low nibble of the status byte. A status read returns the whole byte and then clears those flags.

In loopback mode the control outputs are fed back as status inputs. Outside loopback there are no physical modem pins: the line states take fixed idle values, with carrier and data-set-ready reported high. A single pending output tells the interrupt logic nearby that at least one change flag is set.

Top module: `mdm_status_unit`

## Requirements
- R1: A control write (`wr_en`=1, `wr_sel`=0) stores only data bits 4:0; `ctl_out[7:5]` always reads zero.
- R2: With control bit 4 (loopback) set, status bit 4 (CTS) follows control bit 1, bit 5 (DSR) follows control bit 0, bit 6 (RI) follows control bit 2 and bit 7 (DCD) follows control bit 3, from the cycle after the write.
- R3: With control bit 4 clear, status bits 7:4 read 4'b1010: DCD and DSR high, RI and CTS low.
- R4: A control write that changes CTS, DSR or DCD sets status bit 0, 1 or 3 respectively.
- R5: Status bit 2 is set by a control write that takes RI from 1 to 0; a change of RI from 0 to 1 leaves it unchanged.
- R6: A control write updates status bits 7:4 and keeps every change flag that was already set.
- R7: While `rd_sts` is high, `sts_out` shows the full status byte; in the next cycle bits 3:0 are clear. Flags raised by a control write in the same cycle as the read survive it.
- R8: A write with `wr_sel`=1 (status register) changes neither the status nor the control byte.
- R9: `sts_pend` is high exactly when any of status bits 3:0 is set.
- R10: After reset the control byte is 0x00, the status byte is 0xA0 and `sts_pend` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control, 1 status (discarded) |
| wr_data | input | 8 | Write data |
| rd_sts | input | 1 | Status read strobe; clears the change flags after this cycle |
| ctl_out | output | 8 | Stored control byte |
| sts_out | output | 8 | Current status byte |
| sts_pend | output | 1 | Any change flag set |

## Verification
The hardest case to reach is a status read in the same cycle as a control write that raises new change flags. Old flags must clear while the new ones stay. The bench first builds up flags through two loopback writes with no read between them. It then issues the read and a write that leaves loopback on the same edge. This makes both carrier and clear-to-send change at once, while the old data-set-ready flag is expected to clear. The trailing-edge ring flag is reached only by first driving ring high in loopback and then clearing it.

// File: rtl/mdm_pkg.sv
package mdm_pkg;

    // Control byte bit positions (decoded by this block)
    localparam int unsigned CTL_DTR  = 0;
    localparam int unsigned CTL_RTS  = 1;
    localparam int unsigned CTL_AUX1 = 2;
    localparam int unsigned CTL_AUX2 = 3;
    localparam int unsigned CTL_LOOP = 4;

    // Line states, status bits 7:4 from msb to lsb
    typedef struct packed {
        logic dcd;
        logic ri;
        logic dsr;
        logic cts;
    } lines_t;

    // Change flags, status bits 3:0 from msb to lsb
    typedef struct packed {
        logic dcd_chg;
        logic ri_trail;
        logic dsr_chg;
        logic cts_chg;
    } flags_t;

    typedef struct packed {
        lines_t lines;
        flags_t flags;
    } status_t;

endpackage

// File: rtl/mdm_line_map.sv
module mdm_line_map
    import mdm_pkg::*;
#(
    parameter int unsigned CTL_W      = 5,
    parameter lines_t      IDLE_LINES = 4'b1010
) (
    input  logic [CTL_W-1:0] ctl,
    output lines_t           lines
);

    always_comb begin
        if (ctl[CTL_LOOP]) begin
            lines.cts = ctl[CTL_RTS];
            lines.dsr = ctl[CTL_DTR];
            lines.ri  = ctl[CTL_AUX1];
            lines.dcd = ctl[CTL_AUX2];
        end else begin
            lines = IDLE_LINES;
        end
    end

endmodule

// File: rtl/mdm_change_det.sv
module mdm_change_det
    import mdm_pkg::*;
(
    input  lines_t old_lines,
    input  lines_t new_lines,
    output flags_t raised
);

    always_comb begin
        raised.cts_chg  = old_lines.cts ^ new_lines.cts;
        raised.dsr_chg  = old_lines.dsr ^ new_lines.dsr;
        raised.dcd_chg  = old_lines.dcd ^ new_lines.dcd;
        // only a falling ring line is flagged
        raised.ri_trail = old_lines.ri & ~new_lines.ri;
    end

endmodule

// File: rtl/mdm_status_unit.sv
module mdm_status_unit
    import mdm_pkg::*;
#(
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned CTL_W      = 5,
    parameter lines_t      IDLE_LINES = 4'b1010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_sts,
    output logic [DATA_W-1:0] ctl_out,
    output logic [DATA_W-1:0] sts_out,
    output logic              sts_pend
);

    localparam logic [DATA_W-1:0] CTL_MASK =
        {{(DATA_W-CTL_W){1'b0}}, {CTL_W{1'b1}}};
    localparam int unsigned STS_W = $bits(status_t);

    typedef struct packed {
        logic [DATA_W-1:0] ctl;
        status_t           sts;
    } state_t;

    state_t q, d;

    logic              ctl_write;
    logic [DATA_W-1:0] ctl_next;
    lines_t            lines_next;
    flags_t            raised;

    assign ctl_write = wr_en & ~wr_sel;
    assign ctl_next  = ctl_write ? (wr_data & CTL_MASK) : q.ctl;

    mdm_line_map #(
        .CTL_W      (CTL_W),
        .IDLE_LINES (IDLE_LINES)
    ) u_map (
        .ctl   (ctl_next[CTL_W-1:0]),
        .lines (lines_next)
    );

    mdm_change_det u_det (
        .old_lines (q.sts.lines),
        .new_lines (lines_next),
        .raised    (raised)
    );

    always_comb begin
        flags_t kept;
        d     = q;
        kept  = rd_sts ? flags_t'('0) : q.sts.flags;
        d.ctl = ctl_next;
        if (ctl_write) begin
            d.sts.lines = lines_next;
            d.sts.flags = kept | raised;
        end else begin
            d.sts.flags = kept;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.ctl       <= '0;
            q.sts.lines <= IDLE_LINES;
            q.sts.flags <= '0;
        end else begin
            q <= d;
        end
    end

    assign ctl_out  = q.ctl;
    assign sts_out  = {{(DATA_W-STS_W){1'b0}}, q.sts};
    assign sts_pend = |q.sts.flags;

endmodule

// File: rtl/mdm_status_chk.sv
module mdm_status_chk #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              wr_sel,
    input logic [DATA_W-1:0] wr_data,
    input logic              rd_sts,
    input logic [DATA_W-1:0] ctl_out,
    input logic [DATA_W-1:0] sts_out,
    input logic              sts_pend
);

    // R1
    ctl_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_out[7:5] == 3'b000);

    // R2
    loop_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel && wr_data[4]) |=>
        sts_out[7:4] == {$past(wr_data[3]), $past(wr_data[2]),
                         $past(wr_data[0]), $past(wr_data[1])});

    // R3
    idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_out[4] |-> sts_out[7:4] == 4'b1010);

    // R6
    flags_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_sts |=> (sts_out[3:0] & $past(sts_out[3:0])) == $past(sts_out[3:0]));

    // R7
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sts && !(wr_en && !wr_sel)) |=> sts_out[3:0] == 4'h0);

    // R8
    sts_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel && !rd_sts) |=> ($stable(sts_out) && $stable(ctl_out)));

    // R9
    pend_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_pend) |-> $past(!rd_sts) || $past(wr_en && !wr_sel));

endmodule

bind mdm_status_unit mdm_status_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_mdm_status_unit.sv
module tb_mdm_status_unit;

    localparam time PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_sts = 1'b0;
    logic [7:0] ctl_out, sts_out;
    logic       sts_pend;

    int tests = 0;
    int fails = 0;

    always #(PERIOD/2) clk = ~clk;

    mdm_status_unit dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sts(rd_sts), .ctl_out(ctl_out),
        .sts_out(sts_out), .sts_pend(sts_pend)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic wr_ctl(input logic [7:0] v);
        @(negedge clk); wr_en = 1; wr_sel = 0; wr_data = v;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic rd_status(output logic [7:0] v);
        @(negedge clk); rd_sts = 1; #1 v = sts_out;
        @(negedge clk); rd_sts = 0;
    endtask

    task automatic t_reset();
        chk("R10 ctl", ctl_out, 8'h00);
        chk("R10 sts", sts_out, 8'hA0);
        chk("R10 pend", {7'd0, sts_pend}, 8'h00);
    endtask

    task automatic t_loop_all_on();
        logic [7:0] v;
        wr_ctl(8'hFF);
        chk("R1 ctl mask", ctl_out, 8'h1F);
        chk("R2/R4/R5 rise", sts_out, 8'hF1);
        chk("R9 pend set", {7'd0, sts_pend}, 8'h01);
        rd_status(v);
        chk("R7 read value", v, 8'hF1);
        chk("R7 cleared", sts_out, 8'hF0);
        chk("R9 pend clear", {7'd0, sts_pend}, 8'h00);
    endtask

    task automatic t_fall();
        logic [7:0] v;
        wr_ctl(8'h10);
        chk("R5 trailing ring", sts_out, 8'h0F);
        rd_status(v);
        chk("R7 read", v, 8'h0F);
    endtask

    task automatic t_sticky();
        wr_ctl(8'h11);
        chk("R4 dsr", sts_out, 8'h22);
        wr_ctl(8'h13);
        chk("R6 sticky", sts_out, 8'h33);
    endtask

    task automatic t_sts_write();
        foreach (wr_data[i]) begin end
        for (int k = 0; k < 2; k++) begin
            @(negedge clk); wr_en = 1; wr_sel = 1; wr_data = (k == 0) ? 8'h00 : 8'hFF;
            @(negedge clk); wr_en = 0; wr_sel = 0;
            chk("R8 sts", sts_out, 8'h33);
            chk("R8 ctl", ctl_out, 8'h13);
        end
    endtask

    task automatic t_read_and_write();
        logic [7:0] v;
        @(negedge clk); rd_sts = 1; wr_en = 1; wr_sel = 0; wr_data = 8'h03;
        #1 v = sts_out;
        @(negedge clk); rd_sts = 0; wr_en = 0;
        chk("R7 read same cycle", v, 8'h33);
        chk("R7 new flags survive", sts_out, 8'hA9);
        rd_status(v);
        chk("R3 idle", sts_out, 8'hA0);
    endtask

    task automatic t_idle_write();
        wr_ctl(8'h0F);
        chk("R3 no loop", sts_out, 8'hA0);
        chk("R1 ctl", ctl_out, 8'h0F);
    endtask

    task automatic t_aux1_only();
        wr_ctl(8'h14);
        chk("R2 ring map", sts_out, 8'h4A);
        chk("R9 pend", {7'd0, sts_pend}, 8'h01);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_loop_all_on();
        t_fall();
        t_sticky();
        t_sts_write();
        t_read_and_write();
        t_idle_write();
        t_aux1_only();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(PERIOD * 100000);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule